// File: doc/BRIEF.md
# Serial Pass-Through Pin Router

This block is a serial-bus slave that holds one control byte. The byte decides which of four general-purpose pins take part in a pass-through session. In that session the device hands its own serial bus on to a downstream peripheral. The host writes the control byte in a normal 16-bit access. When chip-select returns high at the end of that access, the selected pins start to carry the bus signals:

- the highest pin carries an inverted copy of chip-select, which serves as the downstream select;
- the next pin carries the serial clock;
- the next pin carries the host data-in;
- the lowest pin feeds its input back to the host data-out.

The session lasts while chip-select stays high, so the host can clock any number of downstream transfers. It ends at once when chip-select falls for the next access to this device. That access is then decoded as a normal register access.

Every frame is two bytes, most significant bit first, and each bit is sampled on a rising serial-clock edge. The command byte carries a read flag in its top bit (1 = read) and the register address in the seven bits below. The data byte follows. The design runs on a fast system clock and detects serial-clock edges in that clock domain. The pin routing itself is combinational from the live bus inputs, so the routed signals pass through without extra delay.

The control state machine has these states:

| State | Meaning |
|---|---|
| IDLE | chip-select high, no session |
| CMD | collecting the command byte |
| WDATA | collecting the write data byte |
| WFULL | 16 bits held, waiting for chip-select to rise |
| RDATA | shifting out read data |
| SKIP | frame ignored until chip-select rises |
| PASS | pass-through session armed |

Its transitions are:

| From | To | Condition |
|---|---|---|
| IDLE | CMD | chip-select falls |
| CMD | WDATA | command completes as a write hit |
| CMD | RDATA | command completes as a read hit |
| CMD | SKIP | command completes with an address miss |
| WDATA | WFULL | data byte completes |
| WFULL | PASS | chip-select rises; the pending nibble is committed |
| WFULL | SKIP | an extra clock edge arrives |
| RDATA | SKIP | read byte completes |
| PASS | CMD | chip-select falls |
| CMD, WDATA, RDATA, SKIP | IDLE | chip-select rises |

Top module: `spr_passthru_router`

## Requirements
- R1: A write frame is the command byte {0, REG_ADDR} followed by a data byte. It updates the four enables from data bits 7..4 when chip-select rises. Bit 7 enables pin index 3, bit 6 pin index 2, bit 5 pin index 1 and bit 4 pin index 0. Data bits 3..0 are ignored.
- R2: After reset all enables are 0, every pin follows its normal value and enable, and sdo_oe is 0.
- R3: Pass-through becomes active one system clock after chip-select rises on a completed write. It stays active while chip-select is high, whatever serial-clock and data activity occurs.
- R4: A frame with fewer than 16 bits, more than 16 bits, or a non-matching address changes no enable and does not start pass-through.
- R5: A falling chip-select ends pass-through combinationally, with no clock edge needed, and the access that follows is decoded normally.
- R6: With pass-through active and enable 3 set, pin index 3 drives the inverse of chip-select (low) with its output enable 1.
- R7: With pass-through active and enable 2 set, pin index 2 drives sclk with its output enable 1.
- R8: With pass-through active and enable 1 set, pin index 1 drives sdi with its output enable 1.
- R9: With pass-through active and enable 0 set, sdo equals pin1_in and sdo_oe is 1. Pin index 0 has its output enable 0.
- R10: A pin whose enable is clear, and every pin when pass-through is inactive, drives pin_norm_val with output enable pin_norm_oe.
- R11: A read frame {1, REG_ADDR} returns {enables, 0000} MSB first on sdo during the data byte, with sdo_oe 1. Outside a read data phase or a routed session, sdo_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, much faster than sclk |
| rst_n | input | 1 | asynchronous active-low reset |
| cs_n | input | 1 | host chip-select, active low |
| sclk | input | 1 | host serial clock, idles low |
| sdi | input | 1 | host serial data in |
| sdo | output | 1 | serial data out value |
| sdo_oe | output | 1 | serial data out enable |
| pin1_in | input | 1 | input level of pin index 0 |
| pin_norm_val | input | 4 | normal-mode drive value per pin |
| pin_norm_oe | input | 4 | normal-mode output enable per pin |
| pin_out | output | 4 | drive value per pin |
| pin_oe | output | 4 | output enable per pin |

## Verification
The bench builds the block with the default 8-bit frame and register address 7'h35, so all 16 enable patterns can be swept. Each pattern is written with a different ignored lower nibble. For each one, all eight combinations of sclk, sdi and pin1_in are driven during the session, and every pin's expected value and enable is computed bit by bit from the pattern. Each session is closed by a falling chip-select, and the same frame then reads the pattern back. This covers the immediate drop-out and the normal decode after a session. Short frames, long frames, a wrong address and a reset taken mid-session cover the rejected and reset cases.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int unsigned PIN_COUNT = 4;

    // Fixed pin roles: the index is the pin position, and R1 ties it to an enable bit.
    localparam int unsigned ROLE_RETURN = 0;
    localparam int unsigned ROLE_DATA   = 1;
    localparam int unsigned ROLE_CLOCK  = 2;
    localparam int unsigned ROLE_SELECT = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_WFULL,
        ST_RDATA,
        ST_SKIP,
        ST_PASS
    } spr_state_e;

endpackage

// File: rtl/spr_frame_rx.sv
module spr_frame_rx #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sclk_rise,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam int unsigned CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sclk_q;
    logic [BYTE_W-2:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;

    // Edges are seen only inside a selected frame.
    assign sclk_rise = sclk & ~sclk_q & ~cs_n;
    assign rx_byte   = {shift_q, sdi};
    assign byte_done = sclk_rise && (cnt_q == LAST_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            shift_q <= '0;
            cnt_q   <= '0;
        end else begin
            sclk_q <= sclk;
            if (cs_n) begin
                shift_q <= '0;
                cnt_q   <= '0;
            end else if (sclk_rise) begin
                shift_q <= rx_byte[BYTE_W-2:0];
                cnt_q   <= byte_done ? '0 : cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spr_ctrl_fsm.sv
module spr_ctrl_fsm
    import spr_pkg::*;
#(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned EN_W     = PIN_COUNT,
    parameter logic [BYTE_W-2:0] REG_ADDR = 7'h35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk_rise,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output spr_state_e        state,
    output logic [EN_W-1:0]   en_q,
    output logic              pass_on,
    output logic              rd_active,
    output logic              rd_bit
);

    localparam int unsigned PAD_W = BYTE_W - EN_W;

    spr_state_e        state_q;
    spr_state_e        state_d;
    logic [EN_W-1:0]   pend_q;
    logic [BYTE_W-1:0] rd_sh_q;
    logic              addr_hit;
    logic              is_read;

    assign addr_hit = (rx_byte[BYTE_W-2:0] == REG_ADDR);
    assign is_read  = rx_byte[BYTE_W-1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_n) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (cs_n) begin
                    state_d = ST_IDLE;
                end else if (byte_done) begin
                    if (!addr_hit)    state_d = ST_SKIP;
                    else if (is_read) state_d = ST_RDATA;
                    else              state_d = ST_WDATA;
                end
            end
            ST_WDATA: begin
                if (cs_n)           state_d = ST_IDLE;
                else if (byte_done) state_d = ST_WFULL;
            end
            ST_WFULL: begin
                if (cs_n)           state_d = ST_PASS;
                else if (sclk_rise) state_d = ST_SKIP;
            end
            ST_RDATA: begin
                if (cs_n)           state_d = ST_IDLE;
                else if (byte_done) state_d = ST_SKIP;
            end
            ST_SKIP: begin
                if (cs_n) state_d = ST_IDLE;
            end
            ST_PASS: begin
                if (!cs_n) state_d = ST_CMD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register contents: pending nibble, committed enables, read shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            en_q    <= '0;
            rd_sh_q <= '0;
        end else begin
            if (state_q == ST_WDATA && byte_done) begin
                pend_q <= rx_byte[BYTE_W-1 -: EN_W];
            end
            if (state_q == ST_WFULL && cs_n) begin
                en_q <= pend_q;
            end
            if (state_q == ST_CMD && byte_done && addr_hit && is_read) begin
                rd_sh_q <= {en_q, {PAD_W{1'b0}}};
            end else if (state_q == ST_RDATA && sclk_rise) begin
                rd_sh_q <= {rd_sh_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // Outputs
    always_comb begin
        state     = state_q;
        pass_on   = (state_q == ST_PASS) && cs_n;
        rd_active = (state_q == ST_RDATA) && !cs_n;
        rd_bit    = rd_sh_q[BYTE_W-1];
    end

endmodule

// File: rtl/spr_pin_mux.sv
module spr_pin_mux
    import spr_pkg::*;
(
    input  logic                 pass_on,
    input  logic [PIN_COUNT-1:0] en,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 sdi,
    input  logic                 pin1_in,
    input  logic                 rd_active,
    input  logic                 rd_bit,
    input  logic [PIN_COUNT-1:0] norm_val,
    input  logic [PIN_COUNT-1:0] norm_oe,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 sdo,
    output logic                 sdo_oe
);

    logic [PIN_COUNT-1:0] route_val;
    logic [PIN_COUNT-1:0] route_oe;
    logic [PIN_COUNT-1:0] take;

    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
        if (g == ROLE_SELECT) begin : g_sel
            assign route_val[g] = ~cs_n;
            assign route_oe[g]  = 1'b1;
        end else if (g == ROLE_CLOCK) begin : g_clk
            assign route_val[g] = sclk;
            assign route_oe[g]  = 1'b1;
        end else if (g == ROLE_DATA) begin : g_dat
            assign route_val[g] = sdi;
            assign route_oe[g]  = 1'b1;
        end else begin : g_ret
            assign route_val[g] = norm_val[g];
            assign route_oe[g]  = 1'b0;
        end
        assign take[g]    = pass_on & en[g];
        assign pin_out[g] = take[g] ? route_val[g] : norm_val[g];
        assign pin_oe[g]  = take[g] ? route_oe[g]  : norm_oe[g];
    end

    always_comb begin
        if (take[ROLE_RETURN]) begin
            sdo    = pin1_in;
            sdo_oe = 1'b1;
        end else if (rd_active) begin
            sdo    = rd_bit;
            sdo_oe = 1'b1;
        end else begin
            sdo    = 1'b0;
            sdo_oe = 1'b0;
        end
    end

endmodule

// File: rtl/spr_passthru_router.sv
module spr_passthru_router
    import spr_pkg::*;
#(
    parameter int unsigned BYTE_W   = 8,
    parameter logic [BYTE_W-2:0] REG_ADDR = 7'h35
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 sdi,
    output logic                 sdo,
    output logic                 sdo_oe,
    input  logic                 pin1_in,
    input  logic [PIN_COUNT-1:0] pin_norm_val,
    input  logic [PIN_COUNT-1:0] pin_norm_oe,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe
);

    logic                 sclk_rise_w;
    logic                 byte_done_w;
    logic [BYTE_W-1:0]    rx_byte_w;
    spr_state_e           state_w;
    logic [PIN_COUNT-1:0] en_w;
    logic                 pass_on_w;
    logic                 rd_active_w;
    logic                 rd_bit_w;

    spr_frame_rx #(
        .BYTE_W (BYTE_W)
    ) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .sclk_rise (sclk_rise_w),
        .byte_done (byte_done_w),
        .rx_byte   (rx_byte_w)
    );

    spr_ctrl_fsm #(
        .BYTE_W   (BYTE_W),
        .EN_W     (PIN_COUNT),
        .REG_ADDR (REG_ADDR)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk_rise (sclk_rise_w),
        .byte_done (byte_done_w),
        .rx_byte   (rx_byte_w),
        .state     (state_w),
        .en_q      (en_w),
        .pass_on   (pass_on_w),
        .rd_active (rd_active_w),
        .rd_bit    (rd_bit_w)
    );

    spr_pin_mux mux_i (
        .pass_on   (pass_on_w),
        .en        (en_w),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .pin1_in   (pin1_in),
        .rd_active (rd_active_w),
        .rd_bit    (rd_bit_w),
        .norm_val  (pin_norm_val),
        .norm_oe   (pin_norm_oe),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

endmodule

// File: rtl/spr_passthru_chk.sv
module spr_passthru_chk
    import spr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 pin1_in,
    input  logic [PIN_COUNT-1:0] pin_norm_val,
    input  logic [PIN_COUNT-1:0] pin_norm_oe,
    input  logic [PIN_COUNT-1:0] pin_out,
    input  logic [PIN_COUNT-1:0] pin_oe,
    input  logic                 sdo,
    input  logic                 sdo_oe,
    input  spr_state_e           state,
    input  logic [PIN_COUNT-1:0] en_q,
    input  logic                 pass_on
);

    // R2
    en_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0));

    // R3
    en_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_q) |-> (cs_n && $past(state) == ST_WFULL));

    // R5
    cs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !pass_on);

    // R10
    normal_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_on |-> (pin_out == pin_norm_val && pin_oe == pin_norm_oe));

    // R6
    sel_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_on && en_q[ROLE_SELECT]) |-> (!pin_out[ROLE_SELECT] && pin_oe[ROLE_SELECT]));

    // R7
    clk_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_on && en_q[ROLE_CLOCK]) |-> (pin_out[ROLE_CLOCK] == sclk && pin_oe[ROLE_CLOCK]));

    // R9
    ret_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_on && en_q[ROLE_RETURN]) |-> (sdo == pin1_in && sdo_oe && !pin_oe[ROLE_RETURN]));

    // R11
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SKIP) |-> !sdo_oe);

endmodule

bind spr_passthru_router spr_passthru_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sclk         (sclk),
    .pin1_in      (pin1_in),
    .pin_norm_val (pin_norm_val),
    .pin_norm_oe  (pin_norm_oe),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .sdo          (sdo),
    .sdo_oe       (sdo_oe),
    .state        (state_w),
    .en_q         (en_w),
    .pass_on      (pass_on_w)
);

// File: tb/spr_passthru_router_tb.sv
module spr_passthru_router_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [6:0] ADDR = 7'h35;
    localparam int unsigned WATCHDOG = 60000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n;
    logic       sclk;
    logic       sdi;
    logic       sdo;
    logic       sdo_oe;
    logic       pin1_in;
    logic [3:0] nval;
    logic [3:0] noe;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spr_passthru_router #(
        .BYTE_W   (8),
        .REG_ADDR (ADDR)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .sdi          (sdi),
        .sdo          (sdo),
        .sdo_oe       (sdo_oe),
        .pin1_in      (pin1_in),
        .pin_norm_val (nval),
        .pin_norm_oe  (noe),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b);
        sdi = b;
        tick(2);
        sclk = 1'b1;
        tick(2);
        sclk = 1'b0;
        tick(1);
    endtask

    task automatic spi_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) spi_bit(v[i]);
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] v);
        cs_n = 1'b0;
        tick(2);
        spi_byte({1'b0, a});
        spi_byte(v);
        cs_n = 1'b1;
        tick(3);
    endtask

    // Read frame; assumes cs_n is already low. Checks sdo bit by bit.
    task automatic read_body(input logic [6:0] a, input logic [7:0] exp, input logic hit, input string req);
        spi_byte({1'b1, a});
        for (int i = 7; i >= 0; i--) begin
            sdi = 1'b0;
            tick(2);
            check(req, {7'd0, sdo_oe}, {7'd0, hit});
            if (hit) check(req, {7'd0, sdo}, {7'd0, exp[i]});
            sclk = 1'b1;
            tick(2);
            sclk = 1'b0;
            tick(1);
        end
        cs_n = 1'b1;
        tick(3);
    endtask

    task automatic read_reg(input logic [7:0] exp, input string req);
        cs_n = 1'b0;
        tick(2);
        read_body(ADDR, exp, 1'b1, req);
    endtask

    task automatic check_normal(input string req);
        check(req, {4'd0, pin_out}, {4'd0, nval});
        check(req, {4'd0, pin_oe}, {4'd0, noe});
        check(req, {7'd0, sdo_oe}, 8'd0);
    endtask

    // Expected pin state during an active session, derived from R6..R10.
    task automatic check_session(input logic [3:0] e);
        logic [3:0] ev;
        logic [3:0] eo;
        ev = nval;
        eo = noe;
        if (e[3]) begin ev[3] = 1'b0;  eo[3] = 1'b1; end
        if (e[2]) begin ev[2] = sclk;  eo[2] = 1'b1; end
        if (e[1]) begin ev[1] = sdi;   eo[1] = 1'b1; end
        if (e[0]) begin eo[0] = 1'b0; end
        check("R6/R7/R8/R10 pin_out", {4'd0, pin_out}, {4'd0, ev});
        check("R6/R7/R8/R9 pin_oe", {4'd0, pin_oe}, {4'd0, eo});
        check("R9 sdo_oe", {7'd0, sdo_oe}, {7'd0, e[0]});
        if (e[0]) check("R9 sdo", {7'd0, sdo}, {7'd0, pin1_in});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        cs_n    = 1'b1;
        sclk    = 1'b0;
        sdi     = 1'b0;
        pin1_in = 1'b0;
        nval    = 4'b0110;
        noe     = 4'b1001;
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R2: reset state
        check_normal("R2 reset pins");
        read_reg(8'h00, "R2 reset enables");

        // Sweep every enable pattern (R1, R3, R5..R11)
        for (int e = 0; e < 16; e++) begin
            logic [3:0] en4;
            en4  = 4'(e);
            nval = ~en4 ^ 4'(e >> 1);
            noe  = en4 ^ 4'b0101;
            write_reg(ADDR, {en4, 4'(e * 7 + 3)});
            // R3: many transfers while cs_n stays high
            for (int c = 0; c < 8; c++) begin
                sclk    = c[0];
                sdi     = c[1];
                pin1_in = c[2];
                #1;
                check_session(en4);
                tick(2);
            end
            sclk = 1'b0;
            sdi  = 1'b0;
            tick(1);
            // R5: falling select ends session without a clock edge
            cs_n = 1'b0;
            #1;
            check_normal("R5 drop on cs fall");
            tick(2);
            // R1 / R11: same frame read back, lower nibble ignored
            read_body(ADDR, {en4, 4'b0000}, 1'b1, "R1/R11 readback");
            // R10: read frame does not arm a session
            check_normal("R10 after read");
        end

        // R4: rejected frames with enables at 1111
        nval = 4'b1010;
        noe  = 4'b0011;
        cs_n = 1'b0;
        tick(2);
        spi_byte({1'b0, ADDR});
        for (int i = 7; i >= 1; i--) spi_bit(1'b0);
        cs_n = 1'b1;
        tick(3);
        check_normal("R4 short frame no session");
        read_reg(8'hF0, "R4 short frame no update");

        cs_n = 1'b0;
        tick(2);
        spi_byte({1'b0, ADDR});
        spi_byte(8'h00);
        spi_bit(1'b0);
        cs_n = 1'b1;
        tick(3);
        check_normal("R4 long frame no session");
        read_reg(8'hF0, "R4 long frame no update");

        write_reg(7'h34, 8'h00);
        check_normal("R4 wrong address no session");
        read_reg(8'hF0, "R4 wrong address no update");
        cs_n = 1'b0;
        tick(2);
        read_body(7'h34, 8'h00, 1'b0, "R11 wrong address sdo quiet");

        // R6/R7/R8 with a live session, then R2 reset mid-session
        write_reg(ADDR, 8'hE0);
        sclk = 1'b1;
        sdi  = 1'b1;
        #1;
        check("R7 sclk high", {7'd0, pin_out[2]}, 8'd1);
        check("R8 sdi high", {7'd0, pin_out[1]}, 8'd1);
        check("R6 select low", {7'd0, pin_out[3]}, 8'd0);
        sclk = 1'b0;
        sdi  = 1'b0;
        tick(1);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(2);
        check_normal("R2 reset ends session");
        read_reg(8'h00, "R2 reset clears enables");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule